// File: doc/BRIEF.md
# Approximate 3x3 Median Filter (Median of Row Medians)

This block takes a full 3x3 neighbourhood of 8-bit samples for each of three colour channels and returns one filtered sample per channel for the centre position. It does not compute the exact median of the nine samples. Instead, each row of three is reduced to its middle value, and the middle value of those three row results becomes the output. The output therefore always lies between the 4th and 6th smallest of the nine samples. Isolated impulse noise (a lone 0 or 255 sample) is removed, and the smoothing effect is close to that of a true median. The cost is four three-input selectors per channel instead of a full sorting network.

Window formation, line storage and the video stream lie outside the block. An upstream stage presents a complete window with `in_valid`. With the default parameter `OUT_REG=1` the result is registered, and `out_valid` follows `in_valid` one cycle later. With `OUT_REG=0` the path is purely combinational.

Each three-input selector compares the pairs (a,b), (b,c) and (c,a). Every comparison gives exactly one of greater, less or equal. A one-hot 3:1 select then routes the middle input. When inputs are equal, the lowest-indexed candidate is routed, which leaves the value unchanged.

Top module: `mom_filter`

## Requirements
- R1: Sample k of channel c (k = 3*row + col, row-major, k = 0 is top-left) sits at `in_pix[(c*9+k)*8 +: 8]`. The three groups are the three rows: k = 0..2, 3..5 and 6..8.
- R2: Each channel's output equals the median of the three row medians of that channel's window. For example, rows {1,2,9}, {3,4,8}, {5,6,7} give 4, although the true median is 5.
- R3: For every window, the number of samples less than or equal to the output is at least 4, and the number of samples greater than or equal to the output is at least 4. The output is therefore rank 4, 5 or 6 of the nine.
- R4: Channel c's result appears at `out_pix[c*8 +: 8]` and depends only on channel c's nine samples.
- R5: Ties do not disturb the result. A window of nine equal samples returns that value, and windows containing two or three equal values in a row return the value that R2 gives.
- R6: With `OUT_REG=1`, `out_valid` equals the `in_valid` of the previous cycle, and `out_pix` then carries the result for the window presented in that cycle.
- R7: With `OUT_REG=1`, `out_pix` changes only in the cycle after a cycle in which `in_valid` was 1. Otherwise it holds its value.
- R8: While `rst_n` is 0, `out_valid` and `out_pix` are 0 (registered variant).
- R9: A single outlier of 0 or 255 in a window whose other samples all lie strictly between 0 and 255 never appears at the output.
- R10: With `OUT_REG=0`, `out_valid` equals `in_valid` and `out_pix` carries the same-cycle result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window on `in_pix` is valid |
| in_pix | input | CHANNELS*9*PIX_W (216) | Nine samples per channel, layout per R1 |
| out_valid | output | 1 | Result on `out_pix` is valid |
| out_pix | output | CHANNELS*PIX_W (24) | One filtered sample per channel |

## Verification
The bench builds two instances with `PIX_W=8` and `CHANNELS=3`: one with `OUT_REG=1`, for the one-cycle latency, the hold behaviour and the reset values, and one with `OUT_REG=0`, for the same-cycle combinational path. Running both from the same stimulus means every window is checked against the reference twice, once per variant. The full 8-bit range makes the 0 and 255 impulse cases reachable. Three channels expose any crosstalk between channel slices. A crafted window separates the median of row medians from the true median.

// File: rtl/mom_pkg.sv
package mom_pkg;
    localparam int WIN_SIDE  = 3;
    localparam int WIN_TAPS  = WIN_SIDE * WIN_SIDE;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } rel_t;
endpackage

// File: rtl/mom_cmp.sv
module mom_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0]  lhs,
    input  logic [W-1:0]  rhs,
    output mom_pkg::rel_t rel
);
    always_comb begin
        rel.gt = (lhs > rhs);
        rel.lt = (lhs < rhs);
        rel.eq = ~rel.gt & ~rel.lt;
    end
endmodule

// File: rtl/mom_med3.sv
module mom_med3 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] mid
);
    mom_pkg::rel_t r_ab, r_bc, r_ca;
    logic a_mid, b_mid;
    logic pick_a, pick_b, pick_c;

    mom_cmp #(.W(W)) u_ab (.lhs(a), .rhs(b), .rel(r_ab));
    mom_cmp #(.W(W)) u_bc (.lhs(b), .rhs(c), .rel(r_bc));
    mom_cmp #(.W(W)) u_ca (.lhs(c), .rhs(a), .rel(r_ca));

    always_comb begin
        // a lies between b and c (either order)
        a_mid  = (~r_ab.lt & ~r_ca.lt) | (~r_ab.gt & ~r_ca.gt);
        // b lies between a and c (either order)
        b_mid  = (~r_ab.gt & ~r_bc.gt) | (~r_ab.lt & ~r_bc.lt);
        // lowest index wins on ties; exactly one pick is raised
        pick_a = a_mid;
        pick_b = b_mid & ~a_mid;
        pick_c = ~a_mid & ~b_mid;
        mid    = ({W{pick_a}} & a) | ({W{pick_b}} & b) | ({W{pick_c}} & c);
    end
endmodule

// File: rtl/mom_channel.sv
module mom_channel #(
    parameter int W = 8
) (
    input  logic [mom_pkg::WIN_TAPS*W-1:0] win,
    output logic [W-1:0]                   med
);
    localparam int SIDE = mom_pkg::WIN_SIDE;

    logic [W-1:0] row_med [SIDE];

    for (genvar r = 0; r < SIDE; r++) begin : g_row
        mom_med3 #(.W(W)) u_row (
            .a  (win[(r*SIDE+0)*W +: W]),
            .b  (win[(r*SIDE+1)*W +: W]),
            .c  (win[(r*SIDE+2)*W +: W]),
            .mid(row_med[r])
        );
    end

    mom_med3 #(.W(W)) u_final (
        .a  (row_med[0]),
        .b  (row_med[1]),
        .c  (row_med[2]),
        .mid(med)
    );
endmodule

// File: rtl/mom_filter.sv
module mom_filter #(
    parameter int PIX_W    = 8,
    parameter int CHANNELS = 3,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        in_valid,
    input  logic [CHANNELS*mom_pkg::WIN_TAPS*PIX_W-1:0] in_pix,
    output logic                                        out_valid,
    output logic [CHANNELS*PIX_W-1:0]                   out_pix
);
    localparam int TAPS  = mom_pkg::WIN_TAPS;
    localparam int WIN_W = TAPS * PIX_W;

    logic [CHANNELS*PIX_W-1:0] med_all;

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
        mom_channel #(.W(PIX_W)) u_chan (
            .win(in_pix[ch*WIN_W +: WIN_W]),
            .med(med_all[ch*PIX_W +: PIX_W])
        );

        // rank and membership of the combinational result (R3, R2)
        logic [3:0] le_cnt, ge_cnt;
        logic       is_member;
        always_comb begin
            le_cnt    = '0;
            ge_cnt    = '0;
            is_member = 1'b0;
            for (int k = 0; k < TAPS; k++) begin
                if (in_pix[ch*WIN_W + k*PIX_W +: PIX_W] <= med_all[ch*PIX_W +: PIX_W])
                    le_cnt = le_cnt + 4'd1;
                if (in_pix[ch*WIN_W + k*PIX_W +: PIX_W] >= med_all[ch*PIX_W +: PIX_W])
                    ge_cnt = ge_cnt + 4'd1;
                if (in_pix[ch*WIN_W + k*PIX_W +: PIX_W] == med_all[ch*PIX_W +: PIX_W])
                    is_member = 1'b1;
            end
        end

        a_r3_rank_window: assert property (@(posedge clk) disable iff (!rst_n)
            (le_cnt >= 4'd4) && (ge_cnt >= 4'd4));
        a_r2_is_a_sample: assert property (@(posedge clk) disable iff (!rst_n)
            is_member);
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                out_pix   <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid)
                    out_pix <= med_all;
            end
        end

        a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid));
        a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(in_valid) |-> $stable(out_pix));
        a_r6_result_loaded: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_pix == $past(med_all)));
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_pix   = med_all;
    end
endmodule

// File: tb/sim_mom_filter.sv
module sim_mom_filter;
    localparam int W   = 8;
    localparam int CH  = 3;
    localparam int WIN = 9 * W;
    localparam int IW  = CH * WIN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] in_pix = '0;
    logic          ov0, ov1;
    logic [CH*W-1:0] op0, op1;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;   // 125 MHz

    mom_filter #(.PIX_W(W), .CHANNELS(CH), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(ov0), .out_pix(op0));

    mom_filter #(.PIX_W(W), .CHANNELS(CH), .OUT_REG(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .out_valid(ov1), .out_pix(op1));

    // ---------------- reference model ----------------
    function automatic int mid3(input int a, input int b, input int c);
        int v [3];
        v[0] = a; v[1] = b; v[2] = c;
        for (int i = 0; i < 2; i++)
            for (int j = 0; j < 2 - i; j++)
                if (v[j] > v[j+1]) begin
                    int t = v[j]; v[j] = v[j+1]; v[j+1] = t;
                end
        return v[1];
    endfunction

    function automatic int sample(input logic [IW-1:0] p, input int c, input int k);
        return int'(p[(c*9+k)*W +: W]);
    endfunction

    function automatic int ref_chan(input logic [IW-1:0] p, input int c);
        int m [3];
        for (int r = 0; r < 3; r++)
            m[r] = mid3(sample(p, c, 3*r), sample(p, c, 3*r+1), sample(p, c, 3*r+2));
        return mid3(m[0], m[1], m[2]);
    endfunction

    function automatic logic [CH*W-1:0] ref_all(input logic [IW-1:0] p);
        logic [CH*W-1:0] r;
        for (int c = 0; c < CH; c++) r[c*W +: W] = W'(ref_chan(p, c));
        return r;
    endfunction

    function automatic bit rank_ok(input logic [IW-1:0] p, input int c, input int y);
        int le = 0, ge = 0;
        for (int k = 0; k < 9; k++) begin
            if (sample(p, c, k) <= y) le++;
            if (sample(p, c, k) >= y) ge++;
        end
        return (le >= 4) && (ge >= 4);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // pending window seen by the registered instance
    logic            pend_v = 1'b0;
    logic [IW-1:0]   pend_p = '0;
    logic [CH*W-1:0] hold_p = '0;

    // One clock: check u0 against the previous drive, drive new, check u1.
    task automatic step(input logic [IW-1:0] p, input logic v);
        @(negedge clk);
        check("R6 out_valid latency", 64'(ov0), 64'(pend_v));
        if (pend_v) hold_p = ref_all(pend_p);
        check("R6/R7 registered result", 64'(op0), 64'(hold_p));
        in_pix   = p;
        in_valid = v;
        pend_v   = v;
        pend_p   = p;
        #1;
        check("R10 comb valid", 64'(ov1), 64'(v));
        check("R2/R4 comb result", 64'(op1), 64'(ref_all(p)));
        for (int c = 0; c < CH; c++) begin
            checks++;
            if (!rank_ok(p, c, int'(op1[c*W +: W]))) begin
                errors++;
                $display("FAIL R3 rank ch%0d: actual=%0d expected rank 4..6", c, op1[c*W +: W]);
            end
        end
    endtask

    function automatic logic [WIN-1:0] win9(input int s0, input int s1, input int s2,
                                            input int s3, input int s4, input int s5,
                                            input int s6, input int s7, input int s8);
        logic [WIN-1:0] w;
        w[0*W +: W] = W'(s0); w[1*W +: W] = W'(s1); w[2*W +: W] = W'(s2);
        w[3*W +: W] = W'(s3); w[4*W +: W] = W'(s4); w[5*W +: W] = W'(s5);
        w[6*W +: W] = W'(s6); w[7*W +: W] = W'(s7); w[8*W +: W] = W'(s8);
        return w;
    endfunction

    function automatic logic [IW-1:0] rnd_win();
        logic [IW-1:0] p;
        for (int i = 0; i < IW / 32 + 1; i++)
            p = {p[IW-33:0], 32'($urandom)};
        return p;
    endfunction

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [IW-1:0] p;
        repeat (3) @(negedge clk);
        // R8: reset state of the registered variant
        check("R8 reset out_valid", 64'(ov0), 64'd0);
        check("R8 reset out_pix", 64'(op0), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 + R1: median of row medians differs from the true median
        p = {win9(1,2,9,3,4,8,5,6,7), win9(9,9,9,1,1,1,5,5,5), win9(1,2,9,3,4,8,5,6,7)};
        step(p, 1'b1);
        check("R2 mom differs from true median", 64'(op1[0 +: W]), 64'd4);
        check("R4 channel 1 independent", 64'(op1[W +: W]), 64'd5);

        // R5: all equal and two-equal tie patterns
        p = {win9(7,7,7,7,7,7,7,7,7), win9(3,3,8,8,2,8,4,4,4), win9(200,200,200,200,200,200,200,200,200)};
        step(p, 1'b1);
        check("R5 all equal ch0", 64'(op1[0 +: W]), 64'd200);
        check("R5 two equal ch1", 64'(op1[W +: W]), 64'd4);
        check("R5 all equal ch2", 64'(op1[2*W +: W]), 64'd7);

        // R7: idle cycles with changing garbage, registered output must hold
        step({IW{1'b1}}, 1'b0);
        step(rnd_win(), 1'b0);
        check("R7 hold during idle", 64'(op0), 64'(ref_all(p)));

        // R9: salt-and-pepper outliers
        p = {win9(100,101,102,103,255,104,105,106,107),
             win9(50,60,70,0,80,90,55,65,75),
             win9(255,10,20,30,40,50,60,70,80)};
        step(p, 1'b1);
        check("R9 salt removed ch0", 64'(op1[0 +: W] == 8'd255), 64'd0);
        check("R9 pepper removed ch1", 64'(op1[W +: W] == 8'd0), 64'd0);
        check("R9 salt removed ch2", 64'(op1[2*W +: W] == 8'd255), 64'd0);

        // R1: ascending ramp, row medians 1,4,7 -> 4
        p = {3{win9(0,1,2,3,4,5,6,7,8)}};
        step(p, 1'b1);
        check("R1 row grouping ramp", 64'(op1[0 +: W]), 64'd4);

        // random windows with random valid
        for (int n = 0; n < 400; n++)
            step(rnd_win(), 1'($urandom_range(0, 3) != 0));
        // back-to-back valid
        for (int n = 0; n < 50; n++)
            step(rnd_win(), 1'b1);
        step('0, 1'b0);
        step('0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule